// File: doc/BRIEF.md
# Capacitive Key Touch Detection Processor

This block turns a stream of burst-length measurements from a four-key capacitive sensing front end into one touch flag per key. Each measurement arrives as a single-cycle sample tagged with the index of the key it belongs to. A touch absorbs charge and shortens the burst, so a touch shows up as a drop of the measurement below a per-key reference level. A rise above the reference, such as a water film bridging the electrodes, is never a touch.

Each key is calibrated from its first few samples, after which it is compared against a threshold set a fixed number of counts below its reference. A touch is confirmed only after several consecutive low samples, and released with hysteresis. While a key is not in detection, its reference slowly follows the signal, faster upward than downward. The step rates and the stuck-key limit are measured in pulses of a slow time-base input. A key held in detection for too long recalibrates itself alone. A select input picks between a short and a long hold limit for all keys.

Top module: `touch_key_proc`

## Requirements
- R1: After reset every flag is low and every key is calibrating. A calibrating key takes 4 of its own samples, keeps its flag low throughout, and sets its reference to the sum of those samples shifted right by 2. Only the next sample of that key is judged for touch.
- R2: A sample of a calibrated key counts as below threshold when reference minus sample is at least 4. A difference of 3 or less never counts toward a touch.
- R3: A sample equal to or above the reference never raises a flag, however large it is.
- R4: A flag rises only on the 3rd consecutive below-threshold sample of that key. Any sample of that key that is not below threshold clears the count to zero.
- R5: A flagged key stays flagged while reference minus sample is 3 or more. It is released by a sample whose difference is 2 or less.
- R6: The time-base divides into an up strobe every 2 pulses and a down strobe every 10 pulses. Each strobe arms a per-key step that the key's next sample consumes. If that key is unflagged, the step moves its reference by one count toward the sample. If the key is flagged, the armed step is discarded and the reference is unchanged.
- R7: A flagged key counts time-base pulses from the moment it is flagged. On the pulse that brings the count to the limit, its flag drops and it recalibrates as in R1, then works normally. The limit is 100 pulses when the hold select is low and 600 when it is high.
- R8: Keys are independent. A sample changes only its own key's flag, and a timeout recalibrates only the key that timed out.
- R9: A flag changes on the clock edge that takes the sample or time-base pulse causing the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid_i | input | 1 | A measurement is present this cycle |
| smp_key_i | input | 2 | Key index of the measurement |
| smp_val_i | input | 12 | Burst-length measurement |
| time_tick_i | input | 1 | Slow time-base pulse, one cycle wide |
| long_hold_i | input | 1 | Hold-limit select: 0 short, 1 long |
| key_touch_o | output | 4 | Touch flag per key, bit n for key n |

## Verification
Every flag is a register updated on the edge that takes the sample or time-base pulse, so each result is due exactly one cycle after its stimulus. The bench applies each stimulus at a falling edge and removes it at the next one. At that second falling edge it compares all four flags with a reference model, so every comparison falls one rising edge after the stimulus. Samples and time-base pulses are never driven in the same cycle, so the model needs no ordering rule between them. Long-horizon effects, such as the 100 and 600 pulse hold limits and drift steps, are checked after counted sequences of single-pulse stimuli. Each of those checks is timed to the pulse on which the change is due.

// File: rtl/tkp_pkg.sv
// Shared types for the touch key processor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tkp_pkg;
    // Phase of one key channel: gathering calibration samples or running.
    typedef enum logic {
        PH_CAL = 1'b0,
        PH_RUN = 1'b1
    } key_phase_e;
endpackage

// File: rtl/tkp_tick_div.sv
// Divides the slow time-base pulse by DIV and emits a one-cycle strobe
// in the same cycle as every DIV-th pulse.
// Assumes tick_i is a single-cycle pulse; DIV >= 1.
module tkp_tick_div #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic strobe_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Strobe on the last pulse of each group.
    assign strobe_o = tick_i && (cnt_q == CW'(DIV - 1));

    // Count pulses, wrapping at DIV.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= strobe_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R6
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DIV - 1));
endmodule

// File: rtl/tkp_key_chan.sv
// One key channel: calibration by averaging, threshold compare, integrator,
// hysteretic release, asymmetric armed drift and stuck-key timeout.
// Assumes hit_i and tick_i may coincide; a timeout wins over a sample.
module tkp_key_chan
    import tkp_pkg::*;
#(
    parameter int unsigned SW      = 12,
    parameter int unsigned THRESH  = 4,
    parameter int unsigned HYST    = 1,
    parameter int unsigned CONFIRM = 3,
    parameter int unsigned CAL_N   = 4,
    parameter int unsigned TW      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic [SW-1:0] sample_i,
    input  logic          tick_i,
    input  logic          up_strobe_i,
    input  logic          dn_strobe_i,
    input  logic [TW-1:0] limit_i,
    output logic          touch_o
);
    localparam int unsigned CAL_LG = $clog2(CAL_N);
    localparam int unsigned ACC_W  = SW + CAL_LG;
    localparam int unsigned CNT_W  = (CAL_LG > 0) ? CAL_LG : 1;
    localparam int unsigned IW     = (CONFIRM > 1) ? $clog2(CONFIRM) : 1;
    localparam int unsigned DW     = SW + 2;
    localparam logic signed [DW-1:0] THR_S = DW'(THRESH);
    localparam logic signed [DW-1:0] REL_S = DW'(THRESH - HYST);

    key_phase_e        phase_q;
    logic [SW-1:0]     ref_q;
    logic [ACC_W-1:0]  acc_q;
    logic [CNT_W-1:0]  ccnt_q;
    logic [IW-1:0]     integ_q;
    logic              det_q;
    logic [TW-1:0]     tmr_q;
    logic              pend_up_q;
    logic              pend_dn_q;

    logic signed [DW-1:0] diff;
    logic                 below;
    logic                 rel;
    logic [ACC_W-1:0]     acc_sum;
    logic [TW:0]          tmr_nx;
    logic                 timeout;

    // Signed distance of the sample below the reference.
    assign diff    = $signed({2'b00, ref_q}) - $signed({2'b00, sample_i});
    assign below   = (diff >= THR_S);
    assign rel     = (diff < REL_S);
    assign acc_sum = acc_q + ACC_W'(sample_i);
    assign tmr_nx  = {1'b0, tmr_q} + 1'b1;
    assign timeout = tick_i && det_q && (tmr_nx >= {1'b0, limit_i});
    assign touch_o = det_q;

    // Armed drift steps: set by strobes, consumed by this key's samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_up_q <= 1'b0;
            pend_dn_q <= 1'b0;
        end else begin
            pend_up_q <= up_strobe_i | (pend_up_q & ~hit_i);
            pend_dn_q <= dn_strobe_i | (pend_dn_q & ~hit_i);
        end
    end

    // Main key state: calibration, detection, drift and hold timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CAL;
            ref_q   <= '0;
            acc_q   <= '0;
            ccnt_q  <= '0;
            integ_q <= '0;
            det_q   <= 1'b0;
            tmr_q   <= '0;
        end else if (timeout) begin
            phase_q <= PH_CAL;
            acc_q   <= '0;
            ccnt_q  <= '0;
            integ_q <= '0;
            det_q   <= 1'b0;
            tmr_q   <= '0;
        end else begin
            if (tick_i && det_q) begin
                tmr_q <= tmr_nx[TW-1:0];
            end
            if (hit_i) begin
                if (phase_q == PH_CAL) begin
                    if (ccnt_q == CNT_W'(CAL_N - 1)) begin
                        ref_q   <= SW'(acc_sum >> CAL_LG);
                        phase_q <= PH_RUN;
                        acc_q   <= '0;
                        ccnt_q  <= '0;
                    end else begin
                        acc_q  <= acc_sum;
                        ccnt_q <= ccnt_q + 1'b1;
                    end
                end else if (det_q) begin
                    if (rel) begin
                        det_q <= 1'b0;
                    end
                end else begin
                    if (below) begin
                        if (integ_q == IW'(CONFIRM - 1)) begin
                            det_q   <= 1'b1;
                            integ_q <= '0;
                            tmr_q   <= '0;
                        end else begin
                            integ_q <= integ_q + 1'b1;
                        end
                    end else begin
                        integ_q <= '0;
                    end
                    if (sample_i > ref_q && pend_up_q) begin
                        ref_q <= ref_q + 1'b1;
                    end else if (sample_i < ref_q && pend_dn_q) begin
                        ref_q <= ref_q - 1'b1;
                    end
                end
            end
        end
    end

    // R1
    cal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CAL) |-> !det_q);

    // R4
    confirm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_q) |-> $past(hit_i && below && phase_q == PH_RUN
                               && integ_q == IW'(CONFIRM - 1)));

    // R3
    no_rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !below) |=> !$rose(det_q));

    // R6
    ref_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q && $past(det_q)) |-> $stable(ref_q));

    // R6
    ref_slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN && $past(phase_q) == PH_RUN) |->
        (ref_q == $past(ref_q) || ref_q == $past(ref_q) + 1'b1
         || ref_q == $past(ref_q) - 1'b1));

    // R5
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det_q) |-> $past((hit_i && rel) || tick_i));

    // R4
    integ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        integ_q <= IW'(CONFIRM - 1));
endmodule

// File: rtl/touch_key_proc.sv
// Touch key processor top: routes tagged samples to per-key channels,
// divides the time base into drift strobes and selects the hold limit.
// Assumes samples for indices >= NKEYS are not presented.
module touch_key_proc
    import tkp_pkg::*;
#(
    parameter int unsigned NKEYS      = 4,
    parameter int unsigned SW         = 12,
    parameter int unsigned THRESH     = 4,
    parameter int unsigned HYST_DIV   = 4,
    parameter int unsigned CONFIRM    = 3,
    parameter int unsigned CAL_N      = 4,
    parameter int unsigned UP_TICKS   = 2,
    parameter int unsigned DN_TICKS   = 10,
    parameter int unsigned HOLD_SHORT = 100,
    parameter int unsigned HOLD_LONG  = 600
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid_i,
    input  logic [$clog2(NKEYS)-1:0] smp_key_i,
    input  logic [SW-1:0]            smp_val_i,
    input  logic                     time_tick_i,
    input  logic                     long_hold_i,
    output logic [NKEYS-1:0]         key_touch_o
);
    localparam int unsigned KEY_W = $clog2(NKEYS);
    localparam int unsigned HMAX  = (HOLD_LONG > HOLD_SHORT) ? HOLD_LONG : HOLD_SHORT;
    localparam int unsigned TW    = $clog2(HMAX + 1);
    localparam int unsigned HYST  = THRESH / HYST_DIV;

    logic          up_strobe;
    logic          dn_strobe;
    logic [TW-1:0] limit;

    // Hold limit shared by all keys.
    assign limit = long_hold_i ? TW'(HOLD_LONG) : TW'(HOLD_SHORT);

    tkp_tick_div #(.DIV(UP_TICKS)) u_up_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (time_tick_i),
        .strobe_o (up_strobe)
    );

    tkp_tick_div #(.DIV(DN_TICKS)) u_dn_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (time_tick_i),
        .strobe_o (dn_strobe)
    );

    for (genvar g = 0; g < NKEYS; g++) begin : g_key
        logic hit;
        assign hit = smp_valid_i && (smp_key_i == KEY_W'(g));

        tkp_key_chan #(
            .SW      (SW),
            .THRESH  (THRESH),
            .HYST    (HYST),
            .CONFIRM (CONFIRM),
            .CAL_N   (CAL_N),
            .TW      (TW)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit_i       (hit),
            .sample_i    (smp_val_i),
            .tick_i      (time_tick_i),
            .up_strobe_i (up_strobe),
            .dn_strobe_i (dn_strobe),
            .limit_i     (limit),
            .touch_o     (key_touch_o[g])
        );
    end

    // R8
    one_key_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(time_tick_i) |-> $countones(key_touch_o ^ $past(key_touch_o)) <= 1);
endmodule

// File: tb/tb_touch_key_proc.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared against a behavioural model written from the requirements.
module tb_touch_key_proc;
    localparam int NK = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [1:0]  smp_key_i = '0;
    logic [11:0] smp_val_i = '0;
    logic        time_tick_i = 1'b0;
    logic        long_hold_i = 1'b0;
    logic [3:0]  key_touch_o;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    // model state
    int m_ref[NK], m_acc[NK], m_ccnt[NK], m_integ[NK], m_tmr[NK];
    bit m_det[NK], m_cal[NK], m_pu[NK], m_pd[NK];
    int m_upc, m_dnc;

    always #4 clk = ~clk;

    touch_key_proc dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid_i (smp_valid_i),
        .smp_key_i   (smp_key_i),
        .smp_val_i   (smp_val_i),
        .time_tick_i (time_tick_i),
        .long_hold_i (long_hold_i),
        .key_touch_o (key_touch_o)
    );

    function automatic logic [3:0] model_flags();
        logic [3:0] f;
        for (int k = 0; k < NK; k++) f[k] = m_det[k];
        return f;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NK; k++) begin
            m_ref[k] = 0; m_acc[k] = 0; m_ccnt[k] = 0; m_integ[k] = 0;
            m_tmr[k] = 0; m_det[k] = 0; m_cal[k] = 1; m_pu[k] = 0; m_pd[k] = 0;
        end
        m_upc = 0; m_dnc = 0;
    endtask

    task automatic model_sample(int k, int v);
        int d;
        if (m_cal[k]) begin
            if (m_ccnt[k] == 3) begin
                m_ref[k] = (m_acc[k] + v) / 4;
                m_cal[k] = 0; m_acc[k] = 0; m_ccnt[k] = 0;
            end else begin
                m_acc[k] += v; m_ccnt[k]++;
            end
        end else begin
            d = m_ref[k] - v;
            if (m_det[k]) begin
                if (d < 3) m_det[k] = 0;
            end else begin
                if (d >= 4) begin
                    if (m_integ[k] == 2) begin
                        m_det[k] = 1; m_integ[k] = 0; m_tmr[k] = 0;
                    end else m_integ[k]++;
                end else m_integ[k] = 0;
                if (v > m_ref[k] && m_pu[k]) m_ref[k]++;
                else if (v < m_ref[k] && m_pd[k]) m_ref[k]--;
            end
        end
        m_pu[k] = 0; m_pd[k] = 0;
    endtask

    task automatic model_tick();
        int lim = long_hold_i ? 600 : 100;
        for (int k = 0; k < NK; k++) begin
            if (m_det[k]) begin
                if (m_tmr[k] + 1 >= lim) begin
                    m_det[k] = 0; m_cal[k] = 1; m_acc[k] = 0;
                    m_ccnt[k] = 0; m_integ[k] = 0; m_tmr[k] = 0;
                end else m_tmr[k]++;
            end
        end
        if (m_upc == 1) begin
            m_upc = 0;
            for (int k = 0; k < NK; k++) m_pu[k] = 1;
        end else m_upc++;
        if (m_dnc == 9) begin
            m_dnc = 0;
            for (int k = 0; k < NK; k++) m_pd[k] = 1;
        end else m_dnc++;
    endtask

    task automatic check_all(string req);
        vectors++;
        if (key_touch_o !== model_flags()) begin
            fails++;
            $display("FAIL %s flags actual=%b expected=%b", req, key_touch_o, model_flags());
        end
    endtask

    task automatic check_bit(string req, int k, bit exp);
        vectors++;
        if (key_touch_o[k] !== exp) begin
            fails++;
            $display("FAIL %s key%0d actual=%b expected=%b", req, k, key_touch_o[k], exp);
        end
    endtask

    // Drive one sample; its effect is visible one rising edge later.
    task automatic send(int k, int v, string req);
        @(negedge clk);
        smp_valid_i = 1'b1; smp_key_i = 2'(k); smp_val_i = 12'(v);
        @(negedge clk);
        smp_valid_i = 1'b0;
        model_sample(k, v);
        check_all(req);
    endtask

    task automatic do_tick(string req);
        @(negedge clk);
        time_tick_i = 1'b1;
        @(negedge clk);
        time_tick_i = 1'b0;
        model_tick();
        check_all(req);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                fails++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        int r, k, v;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_all("R1");
        check_bit("R1", 0, 1'b0);

        // R1: calibration, flags low throughout
        send(0, 100, "R1"); send(0, 102, "R1"); send(0, 104, "R1");
        send(0, 90, "R1");            // sum 396 -> ref 99
        check_bit("R1", 0, 1'b0);
        // recalibrate key0 expectation: ref 99; use that below
        for (int i = 0; i < 4; i++) send(1, 200, "R1");
        send(2, 50, "R1"); send(2, 51, "R1"); send(2, 50, "R1"); send(2, 51, "R1");
        for (int i = 0; i < 4; i++) send(3, 3000, "R1");

        // R2: difference of 3 does not count; R4: interrupted count restarts
        send(0, 96, "R2");
        send(0, 95, "R4"); send(0, 95, "R4");
        check_bit("R4", 0, 1'b0);
        send(0, 99, "R4");
        send(0, 95, "R4"); send(0, 95, "R4");
        check_bit("R4", 0, 1'b0);
        send(0, 95, "R4");
        check_bit("R4", 0, 1'b1);

        // R3: large rise never detects
        for (int i = 0; i < 5; i++) send(1, 900, "R3");
        check_bit("R3", 1, 1'b0);

        // R5: difference 3 holds, 2 releases
        send(0, 96, "R5");
        check_bit("R5", 0, 1'b1);
        send(0, 97, "R5");
        check_bit("R5", 0, 1'b0);

        // R6: up step moves ref 99 -> 100, so 96 now confirms
        do_tick("R6"); do_tick("R6");
        send(0, 110, "R6");
        send(0, 96, "R6"); send(0, 96, "R6"); send(0, 96, "R6");
        check_bit("R6", 0, 1'b1);
        // R6: armed down step discarded while flagged
        for (int i = 0; i < 10; i++) do_tick("R6");
        send(0, 96, "R6");
        send(0, 97, "R6");
        check_bit("R6", 0, 1'b1);
        send(0, 98, "R6");
        check_bit("R6", 0, 1'b0);

        // R7/R8: short limit on key2, key0 flagged 50 pulses later
        long_hold_i = 1'b0;
        send(2, 40, "R7"); send(2, 40, "R7"); send(2, 40, "R7");
        check_bit("R7", 2, 1'b1);
        for (int i = 0; i < 50; i++) do_tick("R7");
        send(0, 85, "R8"); send(0, 85, "R8"); send(0, 85, "R8");
        check_bit("R8", 0, 1'b1);
        for (int i = 0; i < 49; i++) do_tick("R7");
        check_bit("R7", 2, 1'b1);
        do_tick("R7");
        check_bit("R7", 2, 1'b0);
        check_bit("R8", 0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            send(2, 40, "R7");
            check_bit("R7", 2, 1'b0);
        end
        send(2, 40, "R7");
        check_bit("R7", 2, 1'b0);
        send(2, 30, "R7"); send(2, 30, "R7"); send(2, 30, "R7");
        check_bit("R7", 2, 1'b1);

        // R7: long limit on key1
        long_hold_i = 1'b1;
        send(1, 150, "R7"); send(1, 150, "R7"); send(1, 150, "R7");
        check_bit("R7", 1, 1'b1);
        for (int i = 0; i < 599; i++) do_tick("R7");
        check_bit("R7", 1, 1'b1);
        do_tick("R9");
        check_bit("R7", 1, 1'b0);

        // Random traffic against the model (R2..R9)
        for (int n = 0; n < 4000; n++) begin
            r = int'($urandom % 8);
            if ($urandom % 400 == 0) long_hold_i = ~long_hold_i;
            if (r == 0) begin
                do_tick("R9");
            end else begin
                k = int'($urandom % 4);
                if (m_cal[k]) v = 500 + int'($urandom % 50);
                else v = m_ref[k] + int'($urandom % 13) - 8;
                if (v < 0) v = 0;
                if (v > 4095) v = 4095;
                send(k, v, "R8");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule